// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port with a small word-addressed register interface. Software sets an output value and a direction for each pin. It can read back the synchronised level present on every pad. Each pin also feeds an interrupt detector. The detector's trigger condition is chosen from a two-bit code, and a separate per-pin override makes the detector fire on either edge.

Detected events set sticky status bits. Software acknowledges a bit by writing a one to its position. A mask register selects which status bits may raise an interrupt. Pins in the lower half of the port drive one interrupt request line, and pins in the upper half drive the other.

Accesses use a single-cycle strobe. Writes commit on the rising clock edge while `bus_we_i` is high. Read data is combinational from the word index. The default build has 32 pins.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the data, direction, mask, both-edge and both condition registers read 0. `irq_o` is 0 and `pad_oe_o` is 0.
- R2: Word index 0 reads back the last value written to the data register. Word index 1 is the direction register (1 = output). `pad_oe_o` equals the direction bits, and `pad_o` carries the data bit on output pins and 0 elsewhere.
- R3: Word index 2 returns the pad levels after a two-flop synchroniser, whatever the direction, and is valid no later than the third rising edge after a pad change. Writes to index 2 change no register.
- R4: Pin n selects its condition from a two-bit field. For n < N_PINS/2 the field is bits [2n+1:2n] of index 3. Otherwise it is bits [2(n-N_PINS/2)+1:2(n-N_PINS/2)] of index 4. Code 0 sets status while the synchronised pad is low, and code 1 sets it while the pad is high, on every cycle the level holds.
- R5: Code 2 sets status once on a rising edge of the synchronised pad, and code 3 sets it once on a falling edge.
- R6: When bit n of the both-edge register (index 7) is 1, the condition code of pin n is ignored and either edge sets status bit n.
- R7: Status (index 6) is sticky and write-one-to-clear. A 1 written to a bit clears it, and a 0 leaves it unchanged.
- R8: When a detection and a clear hit the same status bit in the same cycle, the bit stays set. A clear therefore does not stick while an active level persists.
- R9: The mask register is word index 5. `irq_o[0]` is the OR of status AND mask over pins below N_PINS/2, and `irq_o[1]` is the same OR over the remaining pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Word index of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, zero-extended above N_PINS |
| pad_i | input | N_PINS | Pad input levels |
| pad_o | output | N_PINS | Pad output values |
| pad_oe_o | output | N_PINS | Pad output enables |
| irq_o | output | 2 | Interrupt requests for the lower and upper pin halves |

## Verification
The bench builds the port with N_PINS = 8, so each half holds four pins and each condition word uses eight bits. This makes a full sweep practical: every pin is run through all four condition codes and the both-edge override. The sweep covers both condition words, both interrupt lines, and every level, edge, sticky-bit and clear interaction on each pin. Expected status values follow directly from the mode number and the pad history.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_PAD    = 3'd2,
    REG_CFG_LO = 3'd3,
    REG_CFG_HI = 3'd4,
    REG_MASK   = 3'd5,
    REG_STAT   = 3'd6,
    REG_BOTH   = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    COND_LOW  = 2'd0,
    COND_HIGH = 2'd1,
    COND_RISE = 2'd2,
    COND_FALL = 2'd3
  } cond_e;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_IRQ  = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  // one more sample of history for edge detection
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stage_q[STAGES-1];

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic       cur_i,
  input  logic       prev_i,
  input  logic [1:0] cond_i,
  input  logic       both_i,
  output logic       set_o
);
  always_comb begin
    if (both_i) begin
      set_o = cur_i ^ prev_i;
    end else begin
      unique case (cond_e'(cond_i))
        COND_LOW:  set_o = ~cur_i;
        COND_HIGH: set_o = cur_i;
        COND_RISE: set_o = cur_i & ~prev_i;
        COND_FALL: set_o = ~cur_i & prev_i;
        default:   set_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned N_PINS = 32,
  localparam int unsigned HALF  = N_PINS / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] set_i,
  input  logic [N_PINS-1:0] clr_i,
  input  logic [N_PINS-1:0] mask_i,
  output logic [N_PINS-1:0] status_o,
  output logic [1:0]        irq_o
);
  logic [N_PINS-1:0] status_q;
  logic [N_PINS-1:0] pend;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;

  assign pend     = status_q & mask_i;
  assign irq_o[0] = |pend[HALF-1:0];
  assign irq_o[1] = |pend[N_PINS-1:HALF];
  assign status_o = status_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  localparam int unsigned HALF  = N_PINS / 2,
  localparam int unsigned CFG_W = 2 * HALF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [1:0]        irq_o
);
  logic [N_PINS-1:0] data_q, dir_q, mask_q, both_q;
  logic [CFG_W-1:0]  cfg_lo_q, cfg_hi_q;
  logic [N_PINS-1:0] pad_cur, pad_prev, pin_set, stat_clr, status;
  logic              wr_en [8];

  for (genvar r = 0; r < 8; r++) begin : g_dec
    assign wr_en[r] = bus_we_i && (bus_addr_i == ADDR_W'(r));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      dir_q    <= '0;
      mask_q   <= '0;
      both_q   <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
    end else begin
      if (wr_en[REG_DATA])   data_q   <= bus_wdata_i[N_PINS-1:0];
      if (wr_en[REG_DIR])    dir_q    <= bus_wdata_i[N_PINS-1:0];
      if (wr_en[REG_MASK])   mask_q   <= bus_wdata_i[N_PINS-1:0];
      if (wr_en[REG_BOTH])   both_q   <= bus_wdata_i[N_PINS-1:0];
      if (wr_en[REG_CFG_LO]) cfg_lo_q <= bus_wdata_i[CFG_W-1:0];
      if (wr_en[REG_CFG_HI]) cfg_hi_q <= bus_wdata_i[CFG_W-1:0];
    end
  end

  assign stat_clr = wr_en[REG_STAT] ? bus_wdata_i[N_PINS-1:0] : '0;

  gpio_sync #(.WIDTH(N_PINS), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_i),
    .sync_o  (pad_cur),
    .prev_o  (pad_prev)
  );

  for (genvar n = 0; n < N_PINS; n++) begin : g_pin
    logic [1:0] cond;
    if (n < HALF) begin : g_lo
      assign cond = cfg_lo_q[2*n +: 2];
    end else begin : g_hi
      assign cond = cfg_hi_q[2*(n-HALF) +: 2];
    end
    gpio_pin_detect u_det (
      .cur_i  (pad_cur[n]),
      .prev_i (pad_prev[n]),
      .cond_i (cond),
      .both_i (both_q[n]),
      .set_o  (pin_set[n])
    );
  end

  gpio_irq_status #(.N_PINS(N_PINS)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (pin_set),
    .clr_i    (stat_clr),
    .mask_i   (mask_q),
    .status_o (status),
    .irq_o    (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (reg_idx_e'(bus_addr_i))
      REG_DATA:   bus_rdata_o[N_PINS-1:0] = data_q;
      REG_DIR:    bus_rdata_o[N_PINS-1:0] = dir_q;
      REG_PAD:    bus_rdata_o[N_PINS-1:0] = pad_cur;
      REG_CFG_LO: bus_rdata_o[CFG_W-1:0]  = cfg_lo_q;
      REG_CFG_HI: bus_rdata_o[CFG_W-1:0]  = cfg_hi_q;
      REG_MASK:   bus_rdata_o[N_PINS-1:0] = mask_q;
      REG_STAT:   bus_rdata_o[N_PINS-1:0] = status;
      REG_BOTH:   bus_rdata_o[N_PINS-1:0] = both_q;
      default:    bus_rdata_o = '0;
    endcase
  end

  assign pad_oe_o = dir_q;
  assign pad_o    = data_q & dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic [N_PINS-1:0] data_q_i,
  input logic [N_PINS-1:0] mask_q_i,
  input logic [N_PINS-1:0] status_i,
  input logic [N_PINS-1:0] set_i,
  input logic [N_PINS-1:0] pad_o_i,
  input logic [N_PINS-1:0] pad_oe_i,
  input logic [1:0]        irq_i
);
  // R2
  data_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_DATA) |=> data_q_i == $past(wdata_i[N_PINS-1:0]));

  // R2
  drive_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o_i & ~pad_oe_i) == '0);

  // R4
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_i & ~$past(status_i) & ~$past(set_i)) == '0);

  // R7
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_STAT) |=>
      (status_i & $past(wdata_i[N_PINS-1:0]) & ~$past(set_i)) == '0);

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> (status_i & $past(set_i)) == $past(set_i));

  // R9
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q_i == '0) |-> irq_i == 2'b00);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (bus_we_i),
  .addr_i   (bus_addr_i),
  .wdata_i  (bus_wdata_i),
  .data_q_i (data_q),
  .mask_q_i (mask_q),
  .status_i (status),
  .set_i    (pin_set),
  .pad_o_i  (pad_o),
  .pad_oe_i (pad_oe_o),
  .irq_i    (irq_o)
);

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  localparam int unsigned NP   = 8;
  localparam int unsigned HALF = NP / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [1:0]    irq;

  int n_chk = 0;
  int n_fail = 0;

  gpio_irq_port #(.N_PINS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_i(pad_in),
    .pad_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] all1;
    all1 = (32'd1 << NP) - 1;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    rd(3'd0, v); chk("R1 data", v, 0);
    rd(3'd1, v); chk("R1 dir", v, 0);
    rd(3'd5, v); chk("R1 mask", v, 0);
    rd(3'd7, v); chk("R1 both", v, 0);
    rd(3'd3, v); chk("R1 cfg_lo", v, 0);
    rd(3'd4, v); chk("R1 cfg_hi", v, 0);
    chk("R1 irq", {30'd0, irq}, 0);
    chk("R1 pad_oe", {24'd0, pad_oe}, 0);
    // R4 default code 0 with low pads sets every status bit
    rd(3'd6, v); chk("R4 low level after reset", v, all1);

    // R2 data and direction
    wr(3'd0, 32'hA5);
    wr(3'd1, 32'h0F);
    rd(3'd0, v); chk("R2 data readback", v, 32'hA5);
    chk("R2 pad_oe", {24'd0, pad_oe}, 32'h0F);
    chk("R2 pad_o", {24'd0, pad_out}, 32'h05);
    // R3 pad status
    pad_in = 8'h3C;
    tick(3);
    rd(3'd2, v); chk("R3 pad level", v, 32'h3C);
    wr(3'd2, 32'hFF);
    rd(3'd0, v); chk("R3 write ignored data", v, 32'hA5);
    rd(3'd1, v); chk("R3 write ignored dir", v, 32'h0F);
    rd(3'd2, v); chk("R3 write ignored pad", v, 32'h3C);
    pad_in = '0;
    wr(3'd1, 32'h0);
    tick(4);

    // sweep every pin through every mode (0..3 codes, 4 = both-edge)
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 5; m++) begin
        logic [31:0] lo, hi, bit_p;
        int line;
        lo = 32'hAAAA_AAAA & ((32'd1 << (2*HALF)) - 1);
        hi = lo;
        bit_p = 32'd1 << p;
        line = (p < HALF) ? 0 : 1;
        if (m < 4) begin
          if (p < HALF) lo = (lo & ~(32'd3 << (2*p))) | (32'(m) << (2*p));
          else          hi = (hi & ~(32'd3 << (2*(p-HALF)))) | (32'(m) << (2*(p-HALF)));
        end else begin
          // code 0 left in place, override must hide it (R6)
          if (p < HALF) lo = lo & ~(32'd3 << (2*p));
          else          hi = hi & ~(32'd3 << (2*(p-HALF)));
        end
        wr(3'd3, lo);
        wr(3'd4, hi);
        wr(3'd7, (m == 4) ? bit_p : 32'd0);
        wr(3'd6, all1);
        rd(3'd6, v); chk("R4 R6 static low", (v >> p) & 1, 32'(m == 0));
        // rising pad; W1C with zero at p must keep bit p (R7)
        pad_in[p] = 1'b1;
        tick(4);
        wr(3'd6, all1 & ~bit_p);
        rd(3'd6, v); chk("R5 R6 R7 after rise", (v >> p) & 1, 32'(m != 3));
        wr(3'd6, bit_p);
        rd(3'd6, v); chk("R7 R8 clear while high", (v >> p) & 1, 32'(m == 1));
        pad_in[p] = 1'b0;
        tick(4);
        rd(3'd6, v); chk("R5 R6 after fall", (v >> p) & 1, 32'(m != 2));
        wr(3'd5, bit_p);
        chk("R9 irq own line", 32'(irq[line]), 32'(m != 2));
        chk("R9 irq other line", 32'(irq[1-line]), 0);
        wr(3'd5, 32'd0);
        wr(3'd6, bit_p);
        rd(3'd6, v); chk("R8 clear while low", (v >> p) & 1, 32'(m == 0));
      end
    end
    finish_run();
  end
endmodule